// File: doc/BRIEF.md
# Ethernet Receive Frame Checker

This block sits behind the receive deframer of an Ethernet MAC. It takes one frame at a time as a byte stream. Preamble and start delimiter are already gone, and the four frame check bytes are still at the tail. On the last beat the stream also carries a count of stray bits that followed the final whole byte.

While the frame flows, the block counts bytes, captures the two-byte length/type field that follows the source address, and runs the CRC-32 over every byte. On the beat after the frame ends it gives four results:
- a keep-or-drop verdict for the buffer manager;
- a status byte for the stored packet header;
- an event pulse for the packet-received bit of the receive status register;
- one event pulse for each error or remote-control bit of that register.

Two configuration inputs decide which errored frames survive. One admits frames that are too short. The other admits frames with a checksum or alignment fault.

The input stream uses a valid/ready handshake. A byte is taken on a rising clock edge only when `in_valid` and `in_ready` are both high. `in_ready` is low during reset and high at all other times, so the block never applies back-pressure once reset has been released. The source may drop `in_valid` between bytes. Such idle cycles do not count as bytes and do not advance the checksum. `in_last` and `in_xbits` are only meaningful on an accepted beat, and `in_xbits` only on the last one.

Top module: `eth_rx_frame_check`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `commit`, `discard` and all event outputs are 0 and `hdr_status` is 00h; `in_ready` is 0 during reset and 1 afterwards.
- R2: A frame of fewer than 64 accepted bytes, FCS included (under 60 bytes without it), sets the short bit, `hdr_status[2]`. A frame of 64 bytes or more does not.
- R3: When accepted bytes 12 and 13 (counting from 0, first byte of the destination address = 0) are 09h and 00h in that order, and the frame holds at least 18 bytes, the remote-control bit `hdr_status[3]` is set. Any other value, or a shorter frame, leaves it clear.
- R4: A nonzero `in_xbits` on the last beat sets the alignment bit, `hdr_status[1]`.
- R5: When the reflected CRC-32 (polynomial 04C11DB7h, preset all ones) over all bytes including the FCS does not leave the magic residue, the CRC bit `hdr_status[0]` is set.
- R6: `hdr_status[7]` is 1 exactly when none of bits 0 to 2 is set. Bits 6:4 are always 0. An error-free frame is always committed.
- R7: With `cfg_accept_bad` = 0 and `cfg_accept_short` = 0, every frame with any of bits 0 to 2 set is discarded.
- R8: Keeping a short frame requires `cfg_accept_short` = 1. Keeping a frame with a CRC or alignment error requires `cfg_accept_bad` = 1. A frame with both kinds of error needs both bits.
- R9: Exactly one of `commit` and `discard` pulses for one cycle, on the cycle after the last beat is accepted. At no other time does either pulse.
- R10: `hdr_status` takes its new value on that same cycle and holds it until the next frame ends.
- R11: `ev_rx_pkt` pulses together with `commit` only. `ev_crc`, `ev_align`, `ev_short` and `ev_remote` pulse with `commit` when the matching status bit is set, and never on a discard.
- R12: A frame whose first byte is accepted on the verdict cycle of the previous frame is judged on its own bytes only. Idle cycles inside a frame do not change its verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_accept_bad | input | 1 | Keep frames with CRC or alignment errors |
| cfg_accept_short | input | 1 | Keep frames below minimum length |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| in_data | input | 8 | Received byte, destination address first |
| in_last | input | 1 | Final byte of the frame (last FCS byte) |
| in_xbits | input | 3 | Stray bits after the last byte, on the last beat |
| commit | output | 1 | One-cycle pulse: keep the frame |
| discard | output | 1 | One-cycle pulse: drop the frame |
| hdr_status | output | 8 | Header status of the most recent frame |
| ev_rx_pkt | output | 1 | Packet stored event |
| ev_remote | output | 1 | Remote-control packet event |
| ev_short | output | 1 | Short-frame event |
| ev_align | output | 1 | Alignment-error event |
| ev_crc | output | 1 | CRC-error event |

## Verification
The verdict for one frame and the first byte of the next frame can land on the same clock edge. On that edge the length counter, the type capture and the CRC register must restart while the verdict registers still hold the results for the old frame. The bench provokes this by starting a frame on the very cycle a discarded, CRC-errored frame is judged. It checks that the first frame's discard and status are intact, and that the second, clean frame is then committed with a good status and no error bits carried over. A further frame with an idle gap placed inside its header confirms that the counter and type capture ignore the gap.

// File: rtl/eth_rxc_pkg.sv
package eth_rxc_pkg;

  localparam int unsigned FCS_BYTES = 4;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // header status byte layout
  typedef struct packed {
    logic       good;
    logic [2:0] rsvd;
    logic       remote;
    logic       short_e;
    logic       align_e;
    logic       crc_e;
  } rx_status_t;

  // one byte through the reflected CRC-32, bit 0 of data first
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] bitrev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

endpackage

// File: rtl/eth_rxc_crc32.sv
module eth_rxc_crc32 #(
  parameter logic [31:0] RESIDUE = 32'hC704DD7B
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       beat,
  input  logic       last,
  input  logic [7:0] data,
  output logic       crc_ok
);
  import eth_rxc_pkg::*;

  // the register runs reflected, so the residue is compared bit-reversed
  localparam logic [31:0] RESIDUE_REFL = bitrev32(RESIDUE);

  logic [31:0] crc_q;
  logic [31:0] crc_nxt;

  assign crc_nxt = crc32_byte(crc_q, data);
  assign crc_ok  = (crc_nxt == RESIDUE_REFL);

  always_ff @(posedge clk) begin
    if (rst)                crc_q <= '1;
    else if (beat && last)  crc_q <= '1;
    else if (beat)          crc_q <= crc_nxt;
  end

  // R12
  crc_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !beat |=> $stable(crc_q));

endmodule

// File: rtl/eth_rxc_track.sv
module eth_rxc_track #(
  parameter int unsigned LEN_W       = 12,
  parameter int unsigned MIN_PAYLOAD = 60,
  parameter int unsigned TYPE_POS    = 12,
  parameter logic [15:0] REMOTE_TYPE = 16'h0900
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       beat,
  input  logic       last,
  input  logic [7:0] data,
  output logic       short_e,
  output logic       remote_e
);
  import eth_rxc_pkg::*;

  localparam logic [LEN_W-1:0] MIN_TOTAL = LEN_W'(MIN_PAYLOAD + FCS_BYTES);
  localparam logic [LEN_W-1:0] POS_HI    = LEN_W'(TYPE_POS);
  localparam logic [LEN_W-1:0] POS_LO    = LEN_W'(TYPE_POS + 1);
  localparam logic [LEN_W-1:0] TYPE_MIN  = LEN_W'(TYPE_POS + 2 + FCS_BYTES);
  localparam logic [LEN_W-1:0] CNT_MAX   = '1;

  logic [LEN_W-1:0] cnt_q, cnt_nxt;
  logic [7:0]       type_hi_q, type_lo_q;
  logic [15:0]      type_cur;

  // bytes so far including the one on this beat, saturating
  assign cnt_nxt  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign type_cur = {(cnt_q == POS_HI) ? data : type_hi_q,
                     (cnt_q == POS_LO) ? data : type_lo_q};

  assign short_e  = (cnt_nxt < MIN_TOTAL);
  assign remote_e = (cnt_nxt >= TYPE_MIN) && (type_cur == REMOTE_TYPE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      type_hi_q <= '0;
      type_lo_q <= '0;
    end else if (beat) begin
      cnt_q     <= last ? '0 : cnt_nxt;
      type_hi_q <= last ? 8'h00 : type_cur[15:8];
      type_lo_q <= last ? 8'h00 : type_cur[7:0];
    end
  end

  // R2
  len_count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (beat && !last && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R12
  len_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !beat |=> $stable(cnt_q));

endmodule

// File: rtl/eth_rxc_verdict.sv
module eth_rxc_verdict (
  input  logic       clk,
  input  logic       rst,
  input  logic       fin,
  input  logic [2:0] xbits,
  input  logic       crc_ok,
  input  logic       short_e,
  input  logic       remote_e,
  input  logic       acc_bad,
  input  logic       acc_short,
  output logic       commit,
  output logic       discard,
  output logic [7:0] status
);
  import eth_rxc_pkg::*;

  rx_status_t st_nxt, st_q;
  logic       any_bad, keep;

  always_comb begin
    st_nxt         = '0;
    st_nxt.crc_e   = !crc_ok;
    st_nxt.align_e = (xbits != 3'd0);
    st_nxt.short_e = short_e;
    st_nxt.remote  = remote_e;
    st_nxt.good    = !(st_nxt.crc_e || st_nxt.align_e || short_e);
  end

  assign any_bad = st_nxt.crc_e || st_nxt.align_e;
  assign keep    = (!any_bad || acc_bad) && (!short_e || acc_short);

  always_ff @(posedge clk) begin
    if (rst) begin
      commit  <= 1'b0;
      discard <= 1'b0;
      st_q    <= '0;
    end else begin
      commit  <= fin && keep;
      discard <= fin && !keep;
      if (fin) st_q <= st_nxt;
    end
  end

  assign status = st_q;

  // R7
  drop_needs_error_chk: assert property (@(posedge clk) disable iff (rst)
    discard |-> (status[2:0] != 3'b000));

  // R7
  strict_keep_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && $past(!acc_bad && !acc_short)) |-> status[7]);

  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fin |=> $stable(st_q));

endmodule

// File: rtl/eth_rx_frame_check.sv
module eth_rx_frame_check #(
  parameter int unsigned LEN_W       = 12,
  parameter int unsigned MIN_PAYLOAD = 60,
  parameter int unsigned TYPE_POS    = 12,
  parameter logic [15:0] REMOTE_TYPE = 16'h0900,
  parameter logic [31:0] RESIDUE     = 32'hC704DD7B
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_accept_bad,
  input  logic       cfg_accept_short,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic [2:0] in_xbits,
  output logic       commit,
  output logic       discard,
  output logic [7:0] hdr_status,
  output logic       ev_rx_pkt,
  output logic       ev_remote,
  output logic       ev_short,
  output logic       ev_align,
  output logic       ev_crc
);

  logic rdy_q;
  logic beat, fin;
  logic crc_ok, short_e, remote_e;

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign beat     = in_valid && rdy_q;
  assign fin      = beat && in_last;

  eth_rxc_crc32 #(.RESIDUE(RESIDUE)) u_crc (
    .clk(clk), .rst(rst), .beat(beat), .last(in_last), .data(in_data), .crc_ok(crc_ok)
  );

  eth_rxc_track #(
    .LEN_W(LEN_W), .MIN_PAYLOAD(MIN_PAYLOAD), .TYPE_POS(TYPE_POS), .REMOTE_TYPE(REMOTE_TYPE)
  ) u_track (
    .clk(clk), .rst(rst), .beat(beat), .last(in_last), .data(in_data),
    .short_e(short_e), .remote_e(remote_e)
  );

  eth_rxc_verdict u_verdict (
    .clk(clk), .rst(rst), .fin(fin), .xbits(in_xbits), .crc_ok(crc_ok),
    .short_e(short_e), .remote_e(remote_e),
    .acc_bad(cfg_accept_bad), .acc_short(cfg_accept_short),
    .commit(commit), .discard(discard), .status(hdr_status)
  );

  assign ev_rx_pkt = commit;
  assign ev_crc    = commit && hdr_status[0];
  assign ev_align  = commit && hdr_status[1];
  assign ev_short  = commit && hdr_status[2];
  assign ev_remote = commit && hdr_status[3];

  // R9
  verdict_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (commit || discard) |-> $past(in_valid && in_ready && in_last));

  // R9
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({commit, discard}));

  // R11
  events_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_crc || ev_align || ev_short || ev_remote) |-> ev_rx_pkt);

  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> in_ready);

endmodule

// File: tb/test_eth_rx_frame_check.sv
`timescale 1ns/100ps
module test_eth_rx_frame_check;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_accept_bad = 1'b0, cfg_accept_short = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [2:0] in_xbits = 3'd0;
  logic       in_ready, commit, discard;
  logic [7:0] hdr_status;
  logic       ev_rx_pkt, ev_remote, ev_short, ev_align, ev_crc;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] fr [0:255];

  always #2.5 clk = ~clk;

  eth_rx_frame_check i_eth_rx_frame_check (
    .clk(clk), .rst(rst), .cfg_accept_bad(cfg_accept_bad), .cfg_accept_short(cfg_accept_short),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_xbits(in_xbits), .commit(commit), .discard(discard), .hdr_status(hdr_status),
    .ev_rx_pkt(ev_rx_pkt), .ev_remote(ev_remote), .ev_short(ev_short),
    .ev_align(ev_align), .ev_crc(ev_crc)
  );

  // len = bytes before FCS, exp_stat: [7]good [3]remote [2]short [1]align [0]crc
  typedef struct packed {
    logic [7:0]  len;
    logic [15:0] ety;
    logic        bad_fcs;
    logic [2:0]  xb;
    logic        acc_bad;
    logic        acc_short;
    logic        exp_commit;
    logic [7:0]  exp_stat;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'd60, 16'h0800, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 8'h80},
    '{8'd60, 16'h0900, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 8'h88},
    '{8'd59, 16'h0800, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h04},
    '{8'd59, 16'h0800, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 8'h04},
    '{8'd64, 16'h0800, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 8'h01},
    '{8'd64, 16'h0800, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 8'h01},
    '{8'd64, 16'h0800, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 8'h02},
    '{8'd64, 16'h0800, 1'b0, 3'd5, 1'b1, 1'b0, 1'b1, 8'h02},
    '{8'd40, 16'h0800, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 8'h05},
    '{8'd40, 16'h0800, 1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 8'h05},
    '{8'd13, 16'h0900, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 8'h04},
    '{8'd14, 16'h0900, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 8'h0C},
    '{8'd60, 16'h0901, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 8'h80},
    '{8'd40, 16'h0900, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 8'h0C}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // serial reference CRC, returns the reflected remainder
  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ fr[i][b];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    return c;
  endfunction

  // build and drive one frame; entered and left at a falling edge
  task automatic send(input int len, input logic [15:0] ety, input logic bad,
                      input logic [2:0] xb, input bit gap);
    logic [31:0] fcs;
    int n;
    for (int i = 0; i < len; i++)
      fr[i] = (i == 12) ? ety[15:8] : (i == 13) ? ety[7:0] : 8'(i * 29 + 5);
    fcs = ~ref_crc(len);
    if (bad) fcs[0] = ~fcs[0];
    for (int k = 0; k < 4; k++) fr[len + k] = fcs[8*k +: 8];
    n = len + 4;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (gap && i == 12) begin
        in_valid = 1'b0;
        in_data  = 8'h55;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = fr[i];
      in_last  = (i == n - 1);
      in_xbits = (i == n - 1) ? xb : 3'd0;
    end
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_xbits = 3'd0;
  endtask

  task automatic check_verdict(input string tag, input logic ec, input logic [7:0] es);
    check({tag, " R9 commit"},  commit,  ec);
    check({tag, " R9 discard"}, discard, !ec);
    check({tag, " R2/R3/R4/R5/R6 status"}, hdr_status, es);
    check({tag, " R11 events"}, {ev_rx_pkt, ev_remote, ev_short, ev_align, ev_crc},
          {ec, ec & es[3], ec & es[2], ec & es[1], ec & es[0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (4) @(negedge clk);
    check("R1 ready in reset", in_ready, 1'b0);
    check("R1 outputs in reset", {commit, discard, hdr_status, ev_rx_pkt, ev_remote,
          ev_short, ev_align, ev_crc}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", in_ready, 1'b1);
    check("R1 outputs after reset", {commit, discard, hdr_status}, '0);

    // table walk: R2..R11
    for (int v = 0; v < NV; v++) begin
      cfg_accept_bad   = VECS[v].acc_bad;
      cfg_accept_short = VECS[v].acc_short;
      send(int'(VECS[v].len), VECS[v].ety, VECS[v].bad_fcs, VECS[v].xb, 1'b0);
      @(negedge clk);
      idle();
      check_verdict($sformatf("vec%0d", v), VECS[v].exp_commit, VECS[v].exp_stat);
      @(negedge clk);
      // R9 single pulse, R10 status held
      check($sformatf("vec%0d R9 pulse ends", v), {commit, discard, ev_rx_pkt}, 3'b000);
      check($sformatf("vec%0d R10 status held", v), hdr_status, VECS[v].exp_stat);
      @(negedge clk);
    end

    // R12 back-to-back: bad frame discarded, clean frame starts on verdict cycle
    cfg_accept_bad = 1'b0; cfg_accept_short = 1'b0;
    send(64, 16'h0800, 1'b1, 3'd0, 1'b0);
    @(negedge clk);
    check_verdict("R12 first of pair", 1'b0, 8'h01);
    send(60, 16'h0900, 1'b0, 3'd0, 1'b0);
    @(negedge clk);
    idle();
    check_verdict("R12 second of pair", 1'b1, 8'h88);
    @(negedge clk);

    // R12 idle gap inside the header does not disturb length, type or CRC
    send(60, 16'h0900, 1'b0, 3'd0, 1'b1);
    @(negedge clk);
    idle();
    check_verdict("R12 gapped frame", 1'b1, 8'h88);

    // R8 short plus alignment needs both accept bits
    cfg_accept_bad = 1'b0; cfg_accept_short = 1'b1;
    @(negedge clk);
    send(30, 16'h0800, 1'b0, 3'd7, 1'b0);
    @(negedge clk);
    idle();
    check_verdict("R8 short+align one bit", 1'b0, 8'h06);
    cfg_accept_bad = 1'b1; cfg_accept_short = 1'b0;
    @(negedge clk);
    send(30, 16'h0800, 1'b0, 3'd1, 1'b0);
    @(negedge clk);
    idle();
    check_verdict("R8 short+align other bit", 1'b0, 8'h06);
    @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule